// File: doc/BRIEF.md
# Protection Group Access Checker

This block gives the final permit or deny verdict on a memory access once address translation has found a matching entry. The matched entry brings two page protection bits and a 4-bit protection group number. The group number picks one of sixteen 2-bit fields in a locally held group rights register. That field then either tightens the page rights or replaces them. The meaning of the field depends on a mode pin.

In key mode, each field holds one key bit for supervisor code and one for user code. The key for the current privilege level is applied. A set key forbids writes and leaves reads to the page rights. In domain mode, the field replaces the page rights outright, chooses deny or free access, or leaves the page rights in charge (client). Software keeps each group tied to the top four bits of the effective page number, so one group covers one fixed sixteenth of the address space.

The verdict is combinational from the lookup inputs and is gated by the hit input. The group rights register is loaded through a 32-bit write port and takes effect from the next clock cycle. All pins are plain control and status signals; there is no streaming interface and no back-pressure.

Top module: `pgac_access_check`

## Requirements
- R1: Group field n sits in register bits [31-2n:30-2n], so group 0 is the top bit pair. Field bit 1 is the supervisor key and field bit 0 is the user key. When `rights_we` is high at a rising clock edge, `rights_wdata` is loaded, and lookups in the following cycles use the new value.
- R2: After reset every field holds 01.
- R3: Page rights are given by `page_prot`. With 00, the supervisor may read and write and the user has no access. With 01, the supervisor may read and write and the user may only read. With 10, both may read and write. With 11, both may only read. `user_mode` = 1 selects user level and 0 selects supervisor level. `is_write` = 1 marks a store.
- R4: In domain mode (`domain_mode` = 1), a field of 00 or 10 denies the access whatever the page rights say.
- R5: In domain mode, a field of 11 permits the access whatever the page rights say.
- R6: In domain mode, a field of 01 (client) leaves the verdict to the page rights alone.
- R7: In key mode (`domain_mode` = 0), the supervisor key (field bit 1) applies when `user_mode` = 0, and the user key (field bit 0) applies when `user_mode` = 1.
- R8: In key mode with the applied key at 1, every write is denied and a read is permitted exactly when the page rights permit reads.
- R9: In key mode with the applied key at 0, the page rights alone decide.
- R10: With `hit` low, both `grant` and `fault` are 0. With `hit` high, exactly one of them is 1.
- R11: The verdict follows the lookup inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rights_we | input | 1 | Load enable for the group rights register |
| rights_wdata | input | 32 | New group rights register value |
| hit | input | 1 | Translation matched; qualifies the verdict |
| group_id | input | 4 | Protection group of the matched entry |
| page_prot | input | 2 | Page protection bits of the matched entry |
| is_write | input | 1 | 1 for a store, 0 for a load |
| user_mode | input | 1 | 1 for user level, 0 for supervisor level |
| domain_mode | input | 1 | 1 for domain mode, 0 for key mode |
| grant | output | 1 | Access permitted |
| fault | output | 1 | Access violation |

## Verification
The bench builds the block with its default of sixteen groups, which is the only group count the register layout allows. With this size the sweep can be made complete. For every group, every field code is placed in the target group while the complementary code fills the other fifteen groups. Each placement is then tried under both modes, all four page codes, both privilege levels and both access kinds. A wrong field slice, a swapped key bit or a misread domain code therefore changes at least one expected verdict. Further checks cover the reset contents and the behaviour with `hit` low.

// File: rtl/pgac_pkg.sv
package pgac_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [1:0] {
    DOM_DENY   = 2'b00,
    DOM_CLIENT = 2'b01,
    DOM_RSVD   = 2'b10,
    DOM_FREE   = 2'b11
  } dom_code_e;

  typedef enum logic [1:0] {
    PG_SRW_UNA = 2'b00,
    PG_SRW_URO = 2'b01,
    PG_ALL_RW  = 2'b10,
    PG_ALL_RO  = 2'b11
  } page_code_e;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
  } rights_t;
endpackage

// File: rtl/pgac_field_bank.sv
module pgac_field_bank
  import pgac_pkg::*;
#(
  parameter int GROUPS = 16,
  localparam int REG_W = GROUPS * FIELD_W,
  localparam int SEL_W = $clog2(GROUPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  input  logic [SEL_W-1:0]   sel,
  output logic [FIELD_W-1:0] field
);
  localparam logic [REG_W-1:0] RESET_VAL = {GROUPS{DOM_CLIENT}};

  logic [REG_W-1:0]   store_q;
  logic [FIELD_W-1:0] slot [GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= RESET_VAL;
    else if (we) store_q <= wdata;
  end

  // group 0 occupies the most significant pair
  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    assign slot[g] = store_q[REG_W-1-FIELD_W*g -: FIELD_W];
  end

  assign field = slot[sel];
endmodule

// File: rtl/pgac_page_rights.sv
module pgac_page_rights
  import pgac_pkg::*;
(
  input  logic [1:0] prot,
  input  logic       user,
  output rights_t    rights
);
  always_comb begin
    rights = '{rd_ok: 1'b1, wr_ok: 1'b1};
    unique case (prot)
      PG_SRW_UNA: rights = user ? '{rd_ok: 1'b0, wr_ok: 1'b0} : '{rd_ok: 1'b1, wr_ok: 1'b1};
      PG_SRW_URO: rights = user ? '{rd_ok: 1'b1, wr_ok: 1'b0} : '{rd_ok: 1'b1, wr_ok: 1'b1};
      PG_ALL_RW:  rights = '{rd_ok: 1'b1, wr_ok: 1'b1};
      PG_ALL_RO:  rights = '{rd_ok: 1'b1, wr_ok: 1'b0};
      default:    rights = '{rd_ok: 1'b0, wr_ok: 1'b0};
    endcase
  end
endmodule

// File: rtl/pgac_group_resolve.sv
module pgac_group_resolve
  import pgac_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               domain,
  input  logic               user,
  input  logic               store,
  input  rights_t            page,
  output logic               allow
);
  logic page_allow;
  logic key_bit;

  assign page_allow = store ? page.wr_ok : page.rd_ok;
  assign key_bit    = user ? field[0] : field[1];

  always_comb begin
    if (domain) begin
      unique case (field)
        DOM_FREE:   allow = 1'b1;
        DOM_CLIENT: allow = page_allow;
        default:    allow = 1'b0;
      endcase
    end else if (key_bit) begin
      allow = !store && page.rd_ok;
    end else begin
      allow = page_allow;
    end
  end
endmodule

// File: rtl/pgac_access_check.sv
module pgac_access_check
  import pgac_pkg::*;
#(
  parameter int GROUPS = 16,
  localparam int REG_W = GROUPS * FIELD_W,
  localparam int SEL_W = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rights_we,
  input  logic [REG_W-1:0] rights_wdata,
  input  logic             hit,
  input  logic [SEL_W-1:0] group_id,
  input  logic [1:0]       page_prot,
  input  logic             is_write,
  input  logic             user_mode,
  input  logic             domain_mode,
  output logic             grant,
  output logic             fault
);
  logic [FIELD_W-1:0] sel_field;
  rights_t            page_r;
  logic               allow;

  pgac_field_bank #(.GROUPS(GROUPS)) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rights_we),
    .wdata (rights_wdata),
    .sel   (group_id),
    .field (sel_field)
  );

  pgac_page_rights page_i (
    .prot   (page_prot),
    .user   (user_mode),
    .rights (page_r)
  );

  pgac_group_resolve resolve_i (
    .field  (sel_field),
    .domain (domain_mode),
    .user   (user_mode),
    .store  (is_write),
    .page   (page_r),
    .allow  (allow)
  );

  assign grant = hit && allow;
  assign fault = hit && !allow;
endmodule

// File: rtl/pgac_access_check_sva.sv
module pgac_access_check_sva
  import pgac_pkg::*;
#(
  parameter int GROUPS = 16,
  localparam int REG_W = GROUPS * FIELD_W,
  localparam int SEL_W = $clog2(GROUPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rights_we,
  input logic [REG_W-1:0] rights_wdata,
  input logic             hit,
  input logic [SEL_W-1:0] group_id,
  input logic             is_write,
  input logic             user_mode,
  input logic             domain_mode,
  input logic             grant,
  input logic             fault
);
  // shadow of the rights register rebuilt from the write port only
  logic [REG_W-1:0]   shadow_q;
  logic [FIELD_W-1:0] sfield;
  logic               skey;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= {GROUPS{DOM_CLIENT}};
    else if (rights_we) shadow_q <= rights_wdata;
  end

  assign sfield = shadow_q[(REG_W-1-FIELD_W*int'(group_id)) -: FIELD_W];
  assign skey   = user_mode ? sfield[0] : sfield[1];

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!grant && !fault));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $onehot({grant, fault}));

  p_dom_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && domain_mode && !sfield[0]) |-> fault);

  p_dom_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && domain_mode && sfield == DOM_FREE) |-> grant);

  p_key_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !domain_mode && skey && is_write) |-> fault);
endmodule

bind pgac_access_check pgac_access_check_sva #(.GROUPS(GROUPS)) sva_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rights_we    (rights_we),
  .rights_wdata (rights_wdata),
  .hit          (hit),
  .group_id     (group_id),
  .is_write     (is_write),
  .user_mode    (user_mode),
  .domain_mode  (domain_mode),
  .grant        (grant),
  .fault        (fault)
);

// File: tb/pgac_access_check_tb.sv
module pgac_access_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GROUPS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rights_we = 1'b0;
  logic [31:0] rights_wdata = '0;
  logic        hit = 1'b0;
  logic [3:0]  group_id = '0;
  logic [1:0]  page_prot = '0;
  logic        is_write = 1'b0;
  logic        user_mode = 1'b0;
  logic        domain_mode = 1'b0;
  logic        grant, fault;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgac_access_check #(.GROUPS(GROUPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rights_we(rights_we), .rights_wdata(rights_wdata),
    .hit(hit), .group_id(group_id), .page_prot(page_prot), .is_write(is_write),
    .user_mode(user_mode), .domain_mode(domain_mode), .grant(grant), .fault(fault)
  );

  // R3 page rights table
  function automatic bit page_ok(int pp, bit usr, bit wr);
    if (!usr) return (pp == 3) ? !wr : 1'b1;
    case (pp)
      0: return 1'b0;
      1: return !wr;
      2: return 1'b1;
      default: return !wr;
    endcase
  endfunction

  function automatic bit expect_allow(bit dom, int v, int pp, bit usr, bit wr);
    bit key;
    if (dom) begin
      if (v == 3) return 1'b1;            // R5
      if (v == 1) return page_ok(pp, usr, wr); // R6
      return 1'b0;                        // R4
    end
    key = usr ? v[0] : v[1];              // R7
    if (key) return !wr && page_ok(pp, usr, 1'b0); // R8
    return page_ok(pp, usr, wr);          // R9
  endfunction

  task automatic check(string req, bit exp_g, bit exp_f);
    total++;
    if (grant !== exp_g || fault !== exp_f) begin
      bad++;
      $display("FAIL %s: grant/fault=%b%b expected %b%b (dom=%0b grp=%0d pp=%0d usr=%0b wr=%0b)",
               req, grant, fault, exp_g, exp_f, domain_mode, group_id, page_prot,
               user_mode, is_write);
    end
  endtask

  task automatic load(logic [31:0] val);
    @(negedge clk);
    rights_wdata = val;
    rights_we = 1'b1;
    @(negedge clk);
    rights_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pat;
    bit e;
    repeat (3) @(negedge clk);
    // R10: quiet in reset and without hit
    check("R10", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset contents all 01 (client in domain mode, user key set in key mode)
    hit = 1'b1; page_prot = 2'd2; is_write = 1'b1;
    for (int g = 0; g < GROUPS; g++) begin
      group_id = 4'(g);
      domain_mode = 1'b1; user_mode = 1'b1; #1;
      check("R2", 1'b1, 1'b0);
      domain_mode = 1'b0; user_mode = 1'b1; #1;
      check("R2", 1'b0, 1'b1);
      domain_mode = 1'b0; user_mode = 1'b0; #1;
      check("R2", 1'b1, 1'b0);
    end

    // R1 R4..R9 R11: exhaustive sweep
    for (int v = 0; v < 4; v++) begin
      for (int g = 0; g < GROUPS; g++) begin
        pat = '0;
        for (int k = 0; k < GROUPS; k++)
          pat[31-2*k -: 2] = (k == g) ? 2'(v) : 2'(~v);
        hit = 1'b0;
        load(pat);
        hit = 1'b1;
        group_id = 4'(g);
        for (int d = 0; d < 2; d++)
          for (int pp = 0; pp < 4; pp++)
            for (int u = 0; u < 2; u++)
              for (int w = 0; w < 2; w++) begin
                domain_mode = d[0]; page_prot = 2'(pp);
                user_mode = u[0]; is_write = w[0];
                #1; // R11 same-cycle response
                e = expect_allow(d[0], v, pp, u[0], w[0]);
                check(d ? "R1/R4-R6" : "R1/R7-R9", e, !e);
              end
        // R10: no hit means silence
        hit = 1'b0; #1;
        check("R10", 1'b0, 1'b0);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule